// File: doc/BRIEF.md
# I2C Paired-Register Slave

This block is the bus-facing half of a serial register target. It watches the two I2C lines (clock and data) through synchronizers on a fast system clock. It recognises Start, repeated Start and Stop, and it answers one 7-bit address, of which the upper bits are fixed and the lower bits come from strap pins. After the write address it takes a command byte and keeps it as a persistent register pointer. It then moves bytes between the bus and an external bank of eight byte-wide registers, and the bank itself lives outside the block.

The eight registers form four pairs, and the pointer's lowest bit selects the member of a pair. After every data byte, in either direction, the pointer moves to the other member of its pair, so a master can stream any number of bytes in one transfer. The lowest pair holds sampled input levels and is read-only: writes to it are acknowledged and then dropped. The block also gives a strobe when each read byte ends, carrying the index of the register read, so that the surrounding logic can clear a change flag. A second strobe marks each Stop.

Top module: `i2cpr_slave`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits equal 4'b0100 followed by the strap value, with bit 0 as direction (1 = read, 0 = write). Any other address gets no acknowledge, and the general call address 0x00 is one of these. After a mismatch, later bytes are neither acknowledged nor written until the next Start.
- R2: After a matching address, and after every byte received in a write (command or data), the block pulls SDA low for the ninth clock.
- R3: The first byte after a write address is the command. Its bits 2:0 load the register pointer and bits 7:3 are ignored. The pointer keeps its value across Stop and is changed only by a new command or by R5.
- R4: Each data byte written produces one wr_en_o pulse with wr_addr_o equal to the pointer and wr_data_o equal to the byte. A byte aimed at index 0 or 1 is acknowledged but produces no pulse.
- R5: After each data byte, read or written, pointer bit 0 inverts and bits 2:1 stay. There is no limit on the number of bytes in a transfer.
- R6: In a read, the block sends the register at the pointer MSB first. Bit 7 appears after the falling clock edge that ends the address acknowledge. A master acknowledge loads the next register. Each read byte ends with a one-cycle rd_ack_o pulse that carries the index of that byte.
- R7: A master NACK ends the read. SDA stays released until the next Start or Stop.
- R8: A repeated Start leaves the pointer on the register being accessed at that moment, so the next read begins there.
- R9: A Stop returns the block to idle with SDA released and gives a one-cycle stop_o pulse.
- R10: sda_pull_o changes only while SCL is low.
- R11: During and after reset, SDA is released, the pointer is 0 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| strap_i | input | STRAP_W | Low address bits from strap pins |
| sda_pull_o | output | 1 | 1 = pull SDA low (open drain) |
| reg_ptr_o | output | IDX_W | Register pointer, used as the bank read address |
| rd_data_i | input | DATA_W | Bank read data at reg_ptr_o |
| wr_en_o | output | 1 | One-cycle write strobe to the bank |
| wr_addr_o | output | IDX_W | Bank write index |
| wr_data_o | output | DATA_W | Bank write data |
| rd_ack_o | output | 1 | One-cycle pulse at the end of each read byte |
| rd_ack_idx_o | output | IDX_W | Index of the byte just read |
| stop_o | output | 1 | One-cycle pulse on Stop |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a fixed upper address of 4'b0100, 8-bit data and a 3-bit index. It ties the straps to 3'b101, which makes the target address 0x25. It can therefore present both a matching address and one that differs only in the strap bits. With an SCL half-period of eight system clocks, the synchronizer delay sits well inside each bus phase. This lets the bench run repeated Start directly after a master acknowledge, and a Stop right after a NACK.

// File: rtl/i2cpr_pkg.sv
package i2cpr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_WR,
    PH_RD,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/i2cpr_line_sync.sv
module i2cpr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  // synchronizer chains, reset to the idle (high) bus level
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cpr_engine.sv
module i2cpr_engine
  import i2cpr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 3,
  parameter int ADDR_W  = 7,
  parameter int STRAP_W = 3,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 4'b0100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               sda_pull,
  output logic [IDX_W-1:0]   ptr,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               rd_stb,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               stop_stb
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  phase_e             ph;
  logic [CNT_W-1:0]   cnt;
  logic               in_ack;
  logic               rw;
  logic               mack;
  logic [DATA_W-1:0]  sh;
  logic               addr_hit;
  logic               wr_allowed;

  assign addr_hit   = (sh[DATA_W-1:DATA_W-ADDR_W] == {ADDR_HI, strap});
  assign wr_allowed = (ptr[IDX_W-1:1] != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      in_ack   <= 1'b0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      sh       <= '0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_stb   <= 1'b0;
      rd_idx   <= '0;
      stop_stb <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      rd_stb   <= 1'b0;
      stop_stb <= 1'b0;
      if (stop_det) begin
        ph       <= PH_IDLE;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
        stop_stb <= 1'b1;
      end else if (start_det) begin
        ph       <= PH_ADDR;
        cnt      <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        case (ph)
          PH_ADDR, PH_CMD, PH_WR: begin
            if (scl_rise && !in_ack && cnt < FULL) begin
              sh  <= {sh[DATA_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && !in_ack && cnt == FULL) begin
              in_ack <= 1'b1;
              if (ph == PH_ADDR) begin
                if (addr_hit) begin
                  sda_pull <= 1'b1;
                  rw       <= sh[0];
                end else begin
                  ph <= PH_HOLD;
                end
              end else if (ph == PH_CMD) begin
                sda_pull <= 1'b1;
                ptr      <= sh[IDX_W-1:0];
              end else begin
                sda_pull <= 1'b1;
                wr_en    <= wr_allowed;
                wr_addr  <= ptr;
                wr_data  <= sh;
                ptr      <= {ptr[IDX_W-1:1], ~ptr[0]};
              end
            end else if (scl_fall && in_ack) begin
              in_ack   <= 1'b0;
              cnt      <= '0;
              sda_pull <= 1'b0;
              if (ph == PH_ADDR) begin
                if (rw) begin
                  ph       <= PH_RD;
                  sh       <= rd_data;
                  sda_pull <= ~rd_data[DATA_W-1];
                end else begin
                  ph <= PH_CMD;
                end
              end else if (ph == PH_CMD) begin
                ph <= PH_WR;
              end
            end
          end
          PH_RD: begin
            if (scl_rise && !in_ack && cnt < FULL) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall && !in_ack && cnt != '0 && cnt < FULL) begin
              sh       <= {sh[DATA_W-2:0], 1'b0};
              sda_pull <= ~sh[DATA_W-2];
            end else if (scl_fall && !in_ack && cnt == FULL) begin
              in_ack   <= 1'b1;
              mack     <= 1'b0;
              sda_pull <= 1'b0;
              rd_stb   <= 1'b1;
              rd_idx   <= ptr;
              ptr      <= {ptr[IDX_W-1:1], ~ptr[0]};
            end else if (scl_rise && in_ack) begin
              mack <= ~sda_s;
            end else if (scl_fall && in_ack) begin
              in_ack <= 1'b0;
              cnt    <= '0;
              if (mack) begin
                sh       <= rd_data;
                sda_pull <= ~rd_data[DATA_W-1];
              end else begin
                ph       <= PH_HOLD;
                sda_pull <= 1'b0;
              end
            end
          end
          default: begin
            sda_pull <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cpr_slave.sv
module i2cpr_slave #(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 3,
  parameter int ADDR_W   = 7,
  parameter int STRAP_W  = 3,
  parameter int SYNC_STG = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 4'b0100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_pull_o,
  output logic [IDX_W-1:0]   reg_ptr_o,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               wr_en_o,
  output logic [IDX_W-1:0]   wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               rd_ack_o,
  output logic [IDX_W-1:0]   rd_ack_idx_o,
  output logic               stop_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cpr_line_sync #(
    .STAGES(SYNC_STG)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cpr_engine #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W),
    .STRAP_W(STRAP_W),
    .ADDR_HI(ADDR_HI)
  ) u_eng (
    .clk      (clk),
    .rst      (rst),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .strap    (strap_i),
    .rd_data  (rd_data_i),
    .sda_pull (sda_pull_o),
    .ptr      (reg_ptr_o),
    .wr_en    (wr_en_o),
    .wr_addr  (wr_addr_o),
    .wr_data  (wr_data_o),
    .rd_stb   (rd_ack_o),
    .rd_idx   (rd_ack_idx_o),
    .stop_stb (stop_o)
  );
endmodule

// File: rtl/i2cpr_checker.sv
module i2cpr_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_i,
  input logic             sda_pull_o,
  input logic [IDX_W-1:0] reg_ptr_o,
  input logic             wr_en_o,
  input logic [IDX_W-1:0] wr_addr_o,
  input logic             rd_ack_o,
  input logic [IDX_W-1:0] rd_ack_idx_o,
  input logic             stop_o
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> !scl_i); // R10

  AST_NO_INPUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_addr_o[IDX_W-1:1] != '0)); // R4

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o); // R4

  AST_WR_PAIR_FLIP: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (reg_ptr_o == {wr_addr_o[IDX_W-1:1], ~wr_addr_o[0]})); // R5

  AST_RD_PAIR_FLIP: assert property (@(posedge clk) disable iff (rst)
    rd_ack_o |-> (reg_ptr_o == {rd_ack_idx_o[IDX_W-1:1], ~rd_ack_idx_o[0]})); // R5

  AST_RD_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
    rd_ack_o |-> !sda_pull_o); // R6

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_o |-> !sda_pull_o); // R9

  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> !stop_o); // R9
endmodule

bind i2cpr_slave i2cpr_checker #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .scl_i       (scl_i),
  .sda_pull_o  (sda_pull_o),
  .reg_ptr_o   (reg_ptr_o),
  .wr_en_o     (wr_en_o),
  .wr_addr_o   (wr_addr_o),
  .rd_ack_o    (rd_ack_o),
  .rd_ack_idx_o(rd_ack_idx_o),
  .stop_o      (stop_o)
);

// File: tb/tb_i2cpr_slave.sv
module tb_i2cpr_slave;
  localparam int Q = 8;
  localparam logic [7:0] WADDR = 8'h4A;
  localparam logic [7:0] RADDR = 8'h4B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m_low = 1'b0;
  logic sda_bus;
  logic sda_pull;
  logic [2:0] reg_ptr, wr_addr, rd_idx;
  logic [7:0] rd_data, wr_data;
  logic wr_en, rd_ack, stop_p;
  logic [7:0] bank [0:7];
  logic [7:0] pin0 = 8'h5A;
  logic [7:0] pin1 = 8'h81;

  int errors = 0;
  int checks = 0;
  int in_we_cnt = 0;
  int we_cnt = 0;
  int rd_cnt = 0;
  int stop_cnt = 0;
  int r10_viol = 0;
  logic [2:0] last_rd_idx = '0;
  logic prev_pull = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = ~(sda_m_low | sda_pull);
  assign rd_data = (reg_ptr[2:1] == 2'b00) ? (reg_ptr[0] ? pin1 : pin0) : bank[reg_ptr];

  i2cpr_slave dut (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .strap_i     (3'b101),
    .sda_pull_o  (sda_pull),
    .reg_ptr_o   (reg_ptr),
    .rd_data_i   (rd_data),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .rd_ack_o    (rd_ack),
    .rd_ack_idx_o(rd_idx),
    .stop_o      (stop_p)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        bank[wr_addr] <= wr_data;
        we_cnt <= we_cnt + 1;
        if (wr_addr[2:1] == 2'b00) in_we_cnt <= in_we_cnt + 1;
      end
      if (rd_ack) begin
        rd_cnt <= rd_cnt + 1;
        last_rd_idx <= rd_idx;
      end
      if (stop_p) stop_cnt <= stop_cnt + 1;
      if (sda_pull != prev_pull && scl_m) r10_viol <= r10_viol + 1;
      prev_pull <= sda_pull;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hc();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; sda_m_low = 1'b0; hc();
    scl_m = 1'b1; hc();
    sda_m_low = 1'b1; hc();
    scl_m = 1'b0; hc();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m_low = 1'b1; hc();
    scl_m = 1'b1; hc();
    sda_m_low = 1'b0; hc();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m_low = ~b[i]; hc();
      scl_m = 1'b1; hc();
      scl_m = 1'b0;
    end
    sda_m_low = 1'b0; hc();
    scl_m = 1'b1; hc();
    acked = ~sda_bus;
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hc();
      scl_m = 1'b1; hc();
      b[i] = sda_bus;
      scl_m = 1'b0;
    end
    sda_m_low = give_ack; hc();
    scl_m = 1'b1; hc();
    scl_m = 1'b0;
    sda_m_low = 1'b0;
  endtask

  task automatic t_reset();
    chk(sda_pull == 1'b0, "R11 sda released", sda_pull, 0);
    chk(reg_ptr == 3'd0, "R11 pointer zero", reg_ptr, 0);
    chk(!wr_en && !rd_ack && !stop_p, "R11 strobes low", {wr_en, rd_ack, stop_p}, 0);
  endtask

  task automatic t_address();
    logic a;
    int we0;
    we0 = we_cnt;
    bus_start();
    send_byte(8'h48, a);
    chk(a == 1'b0, "R1 strap mismatch not acked", a, 0);
    send_byte(8'h04, a);
    chk(a == 1'b0, "R1 byte after mismatch not acked", a, 0);
    send_byte(8'h77, a);
    bus_stop(); hc();
    chk(we_cnt == we0, "R1 no write after mismatch", we_cnt, we0);
    chk(sda_pull == 1'b0, "R9 released after stop", sda_pull, 0);
    bus_start();
    send_byte(8'h00, a);
    chk(a == 1'b0, "R1 general call not acked", a, 0);
    bus_stop(); hc();
  endtask

  task automatic t_write_pair();
    logic a1, a2, a3, a4;
    int s0;
    s0 = stop_cnt;
    bus_start();
    send_byte(WADDR, a1);
    send_byte(8'h02, a2);
    send_byte(8'hA5, a3);
    send_byte(8'h3C, a4);
    bus_stop(); hc();
    chk(a1, "R1 matching address acked", a1, 1);
    chk(a2 && a3 && a4, "R2 write bytes acked", {a2, a3, a4}, 7);
    chk(bank[2] == 8'hA5, "R4 first byte to index 2", bank[2], 8'hA5);
    chk(bank[3] == 8'h3C, "R5 second byte to pair partner", bank[3], 8'h3C);
    chk(stop_cnt == s0 + 1, "R9 one stop pulse", stop_cnt, s0 + 1);
  endtask

  task automatic t_write_stream();
    logic a;
    bus_start();
    send_byte(WADDR, a);
    send_byte(8'hF7, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    bus_stop(); hc();
    chk(bank[7] == 8'h33, "R3 upper command bits ignored, R5 third byte", bank[7], 8'h33);
    chk(bank[6] == 8'h22, "R5 alternation in stream", bank[6], 8'h22);
    chk(reg_ptr == 3'd6, "R5 pointer after three bytes", reg_ptr, 6);
  endtask

  task automatic t_input_ignore();
    logic a;
    logic [7:0] b0, b1;
    int r0;
    bus_start();
    send_byte(WADDR, a);
    send_byte(8'h00, a);
    send_byte(8'hFF, a);
    chk(a, "R4 input write acked", a, 1);
    bus_stop(); hc();
    chk(in_we_cnt == 0, "R4 no strobe for input index", in_we_cnt, 0);
    r0 = rd_cnt;
    bus_start();
    send_byte(WADDR, a);
    send_byte(8'h00, a);
    bus_start();
    send_byte(RADDR, a);
    recv_byte(1'b1, b0);
    recv_byte(1'b0, b1);
    chk(b0 == pin0, "R4 input register unchanged, R6 read", b0, pin0);
    chk(b1 == pin1, "R5 read partner", b1, pin1);
    hc();
    scl_m = 1'b1; hc();
    chk(sda_bus == 1'b1, "R7 released after nack", sda_bus, 1);
    scl_m = 1'b0; hc();
    bus_stop(); hc();
    chk(rd_cnt == r0 + 2, "R6 read strobe per byte", rd_cnt, r0 + 2);
    chk(last_rd_idx == 3'd1, "R6 strobe index", last_rd_idx, 1);
  endtask

  task automatic t_persist();
    logic a;
    logic [7:0] b0, b1, b2;
    bus_start();
    send_byte(WADDR, a);
    send_byte(8'h03, a);
    bus_stop(); hc();
    bus_start();
    send_byte(RADDR, a);
    recv_byte(1'b1, b0);
    recv_byte(1'b1, b1);
    recv_byte(1'b0, b2);
    bus_stop(); hc();
    chk(b0 == 8'h3C, "R3 command persists over stop", b0, 8'h3C);
    chk(b1 == 8'hA5, "R5 read alternation", b1, 8'hA5);
    chk(b2 == 8'h3C, "R5 read back again", b2, 8'h3C);
  endtask

  task automatic t_restart();
    logic a;
    logic [7:0] b0, b1;
    pin0 = 8'hC5;
    bus_start();
    send_byte(WADDR, a);
    send_byte(8'h01, a);
    bus_start();
    send_byte(RADDR, a);
    recv_byte(1'b1, b0);
    chk(b0 == pin1, "R6 first read at command", b0, pin1);
    bus_start();
    send_byte(RADDR, a);
    recv_byte(1'b0, b1);
    bus_stop(); hc();
    chk(b1 == 8'hC5, "R8 restart resumes at accessed register", b1, 8'hC5);
  endtask

  task automatic finish_run();
    chk(r10_viol == 0, "R10 sda changes with scl low", r10_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) bank[i] = 8'h00;
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_address();
    t_write_pair();
    t_write_stream();
    t_input_ignore();
    t_persist();
    t_restart();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule